// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two 16-bit unsigned or two's-complement operands and a carry input in pure combinational logic. The operand width is split into 4-bit slices. Each slice forms its carries directly from per-bit generate and propagate terms. Each slice also reports a slice-wide generate and propagate pair. A second lookahead stage takes those pairs and the carry input, and from them forms the carry into every slice and the final carry output. No carry ever ripples from one slice to the next.

The outputs are the sum, the carry out of the top bit, and a signed overflow flag. The flag is raised when the carry into the top bit differs from the carry out of it. A user applies operands and takes the results in the same cycle. The only delay is the logic delay, which is fixed by the two lookahead levels.

Top module: `cla_adder16`

## Requirements
- R1: `sum` equals (`op_a` + `op_b` + `carry_in`) modulo 2^16 for every operand pair and both carry-input values.
- R2: `carry_out` equals bit 16 of the unsigned 17-bit total `op_a` + `op_b` + `carry_in`.
- R3: `ovf` is 1 exactly when `op_a` bit 15 equals `op_b` bit 15 and `sum` bit 15 differs from them. This is the case where the signed result lies outside the range -32768 to 32767.
- R4: With both operands all ones (0xFFFF) and `carry_in` = 1, `sum` is 0xFFFF, `carry_out` is 1 and `ovf` is 0. With `op_a` = 0xFFFF, `op_b` = 0 and `carry_in` = 1, `sum` is 0, `carry_out` is 1 and `ovf` is 0.
- R5: A carry crosses each slice boundary at bits 4, 8 and 12 correctly. For example, 0x000F + 0x0000 + 1 gives 0x0010, 0x00FF + 0x0001 gives 0x0100, and 0x0FFF + 0x0001 gives 0x1000.
- R6: At the signed edges, 0x7FFF + 0x0001 raises `ovf` and gives 0x8000. 0x8000 + 0xFFFF raises `ovf` and `carry_out` and gives 0x7FFF. 0x7FFF + 0x8000 leaves `ovf` at 0.
- R7: With `op_b` = 0 and `carry_in` = 0, `sum` equals `op_a` and `carry_out` and `ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| ovf | output | 1 | Two's-complement overflow |

## Verification
Every result is due in the same cycle as its operands, because no register lies between inputs and outputs. The bench drives a new operand set on a rising clock edge and samples all three outputs on the next falling edge. By then the logic has settled, and no drive coincides with the sample. Expected values come from plain 17-bit arithmetic in the bench. The stimulus is a cross of hand-picked boundary operands with both carry values, followed by a long pseudo-random run.

// File: rtl/cla_pkg.sv
package cla_pkg;
  parameter int unsigned CLA_SLICE_BITS = 4;
endpackage

// File: rtl/cla_lookahead.sv
// Flattened lookahead: every carry is a sum of products of g, p and c0.
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] g,
  input  logic [N-1:0] p,
  input  logic         c0,
  output logic [N:0]   c
);
  always_comb begin
    c[0] = c0;
    for (int k = 0; k < N; k++) begin
      logic acc;
      logic chain;
      acc   = g[k];
      chain = p[k];
      for (int j = k - 1; j >= 0; j--) begin
        acc   = acc | (chain & g[j]);
        chain = chain & p[j];
      end
      c[k+1] = acc | (chain & c0);
    end
  end
endmodule

// File: rtl/cla_slice.sv
// One slice: local lookahead plus a slice-wide generate/propagate pair.
module cla_slice #(
  parameter int unsigned BITS = cla_pkg::CLA_SLICE_BITS
) (
  input  logic [BITS-1:0] a,
  input  logic [BITS-1:0] b,
  input  logic            cin,
  output logic [BITS-1:0] s,
  output logic            grp_g,
  output logic            grp_p
);
  logic [BITS-1:0] g_bit;
  logic [BITS-1:0] p_bit;
  logic [BITS:0]   c_loc;

  assign g_bit = a & b;
  assign p_bit = a ^ b;

  cla_lookahead #(.N(BITS)) u_la (
    .g  (g_bit),
    .p  (p_bit),
    .c0 (cin),
    .c  (c_loc)
  );

  assign s = p_bit ^ c_loc[BITS-1:0];

  always_comb begin
    logic chain;
    grp_g = g_bit[BITS-1];
    chain = p_bit[BITS-1];
    for (int j = BITS - 2; j >= 0; j--) begin
      grp_g = grp_g | (chain & g_bit[j]);
      chain = chain & p_bit[j];
    end
    grp_p = &p_bit;
  end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             ovf
);
  localparam int unsigned SB = CLA_SLICE_BITS;
  localparam int unsigned NS = WIDTH / SB;

  logic [NS-1:0] sl_g;
  logic [NS-1:0] sl_p;
  logic [NS:0]   sl_c;

  for (genvar i = 0; i < NS; i++) begin : g_slice
    cla_slice #(.BITS(SB)) u_slice (
      .a     (op_a[i*SB +: SB]),
      .b     (op_b[i*SB +: SB]),
      .cin   (sl_c[i]),
      .s     (sum[i*SB +: SB]),
      .grp_g (sl_g[i]),
      .grp_p (sl_p[i])
    );
  end

  cla_lookahead #(.N(NS)) u_top_la (
    .g  (sl_g),
    .p  (sl_p),
    .c0 (carry_in),
    .c  (sl_c)
  );

  logic c_into_msb;
  assign carry_out  = sl_c[NS];
  assign c_into_msb = sum[WIDTH-1] ^ op_a[WIDTH-1] ^ op_b[WIDTH-1];
  assign ovf        = c_into_msb ^ carry_out;
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out,
  input logic             ovf
);
  logic [WIDTH:0] tot;
  assign tot = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    AST_SUM_MATCH: assert (sum == tot[WIDTH-1:0]) else $error("sum mismatch"); // R1
    AST_CARRY_OUT: assert (carry_out == tot[WIDTH]) else $error("carry mismatch"); // R2
    AST_NO_OVERFLOW: assert (ovf == ((op_a[WIDTH-1] == op_b[WIDTH-1]) && (sum[WIDTH-1] != op_a[WIDTH-1]))) else $error("ovf mismatch"); // R3
    AST_ALL_ONES: assert (!(&op_a && &op_b && carry_in) || (&sum && carry_out && !ovf)) else $error("all-ones case"); // R4
    AST_ZERO_ID: assert (!(op_b == '0 && !carry_in) || (sum == op_a && !carry_out && !ovf)) else $error("identity case"); // R7
  end
endmodule

bind cla_adder16 cla_adder16_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .sum       (sum),
  .carry_out (carry_out),
  .ovf       (ovf)
);

// File: tb/cla_adder16_test.sv
`timescale 1ns/1ps
module cla_adder16_test;
  logic        clk;
  logic [15:0] a, b;
  logic        ci;
  logic [15:0] s;
  logic        co, ov;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cla_adder16 uut (
    .op_a(a), .op_b(b), .carry_in(ci),
    .sum(s), .carry_out(co), .ovf(ov)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic apply(input logic [15:0] xa, input logic [15:0] xb, input logic xc, input string tag);
    logic [16:0] tot;
    logic        eov;
    @(posedge clk);
    a = xa; b = xb; ci = xc;
    @(negedge clk);
    tot = {1'b0, xa} + {1'b0, xb} + {16'd0, xc};
    eov = (xa[15] == xb[15]) && (tot[15] != xa[15]);
    checks++;
    if (s !== tot[15:0]) begin
      fails++;
      $display("FAIL %s R1 sum a=%h b=%h c=%0d actual=%h expected=%h", tag, xa, xb, xc, s, tot[15:0]);
    end
    checks++;
    if (co !== tot[16]) begin
      fails++;
      $display("FAIL %s R2 carry a=%h b=%h c=%0d actual=%0d expected=%0d", tag, xa, xb, xc, co, tot[16]);
    end
    checks++;
    if (ov !== eov) begin
      fails++;
      $display("FAIL %s R3 ovf a=%h b=%h c=%0d actual=%0d expected=%0d", tag, xa, xb, xc, ov, eov);
    end
  endtask

  task automatic expect_fixed(input logic [15:0] es, input logic ec, input logic eo, input string tag);
    checks++;
    if (s !== es || co !== ec || ov !== eo) begin
      fails++;
      $display("FAIL %s actual=%h/%0d/%0d expected=%h/%0d/%0d", tag, s, co, ov, es, ec, eo);
    end
  endtask

  logic [15:0] corner [12];

  initial begin
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'h7FFF;
    corner[3] = 16'h8000; corner[4] = 16'hFFFF; corner[5] = 16'h000F;
    corner[6] = 16'h00FF; corner[7] = 16'h0FFF; corner[8] = 16'h5555;
    corner[9] = 16'hAAAA; corner[10] = 16'h8001; corner[11] = 16'hFFFE;
    a = '0; b = '0; ci = 1'b0;

    apply(16'h0000, 16'h0000, 1'b0, "reset-state");
    expect_fixed(16'h0000, 1'b0, 1'b0, "R7 zero inputs");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R4");
    expect_fixed(16'hFFFF, 1'b1, 1'b0, "R4 all ones");
    apply(16'hFFFF, 16'h0000, 1'b1, "R4");
    expect_fixed(16'h0000, 1'b1, 1'b0, "R4 full ripple");
    apply(16'h000F, 16'h0000, 1'b1, "R5");
    expect_fixed(16'h0010, 1'b0, 1'b0, "R5 boundary 4");
    apply(16'h00FF, 16'h0001, 1'b0, "R5");
    expect_fixed(16'h0100, 1'b0, 1'b0, "R5 boundary 8");
    apply(16'h0FFF, 16'h0001, 1'b0, "R5");
    expect_fixed(16'h1000, 1'b0, 1'b0, "R5 boundary 12");
    apply(16'h7FFF, 16'h0001, 1'b0, "R6");
    expect_fixed(16'h8000, 1'b0, 1'b1, "R6 positive overflow");
    apply(16'h8000, 16'hFFFF, 1'b0, "R6");
    expect_fixed(16'h7FFF, 1'b1, 1'b1, "R6 negative overflow");
    apply(16'h7FFF, 16'h8000, 1'b0, "R6");
    expect_fixed(16'hFFFF, 1'b0, 1'b0, "R6 mixed signs");
    apply(16'h1234, 16'h0000, 1'b0, "R7");
    expect_fixed(16'h1234, 1'b0, 1'b0, "R7 identity");

    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int c = 0; c < 2; c++)
          apply(corner[i], corner[j], c[0], "corner R1 R2 R3");

    begin
      logic [31:0] lf;
      lf = 32'hACE1_1234;
      for (int n = 0; n < 40000; n++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        apply(lf[15:0], lf[31:16], lf[7] ^ lf[20], "random R1 R2 R3");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule